// File: doc/BRIEF.md
# Packed Decimal Adder, Subtractor and Comparator

This block adds, subtracts or compares two unsigned decimal numbers of sixteen digits. Each digit sits in its own four-bit nibble of a 64-bit word, with digit 0 in bits 3:0. A request is accepted on any clock where `in_valid` is high. The answer appears in output registers on the following clock.

Decimal correction is not a second step after a binary add. Each digit builds four candidate nibbles in parallel: the plain sum, the sum plus one, and a corrected copy of each. Each digit also produces a generate signal and a propagate signal. A carry network spans all sixteen digits and resolves every digit's incoming carry at once. A final multiplexer per digit then picks one of its four candidates, using the incoming carry and its own outgoing carry. The network is either a ripple chain or a log-depth prefix tree, selected by a parameter.

Subtraction adds the bitwise complement of the second operand and injects a carry into digit 0. A missing carry out of the top digit means a negative difference, which is left in ten's-complement form. Compare runs the same subtraction but writes only the three compare flags.

Top module: `dec_addsub`

## Requirements
- R1: The operation code `op_i` is encoded as follows: 0 adds, 1 subtracts, and 2 or 3 compares. `out_valid` is high on exactly the clocks that follow a clock with `in_valid` high. All results are registered and appear one clock after the request.
- R2: Addition sets `res_q` to (A+B) mod 10^16. It sets `carry_q` high exactly when A+B ≥ 10^16.
- R3: Subtraction sets `carry_q` high exactly when A ≥ B. When A ≥ B, `res_q` is A−B. When A < B, `res_q` is 10^16 − (B−A).
- R4: Compare sets exactly one of `cmp_eq`, `cmp_lt` and `cmp_gt`, according to A versus B. It leaves `res_q` and `carry_q` unchanged.
- R5: `bad_digit` is registered with every accepted request. It is high when any nibble of A or B exceeds 9. The other outputs are then undefined.
- R6: An add or subtract request leaves the three compare flags unchanged.
- R7: After reset, every output is zero.
- R8: A clock with `in_valid` low changes no output except `out_valid`, which goes low.
- R9: With valid digits in both operands, every nibble written to `res_q` is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_i | input | 2 | 0 add, 1 subtract, 2/3 compare |
| a_i | input | 64 | First operand, 16 BCD digits |
| b_i | input | 64 | Second operand, 16 BCD digits |
| out_valid | output | 1 | Result registers were updated by a request |
| res_q | output | 64 | Sum or difference, 16 BCD digits |
| carry_q | output | 1 | Decimal carry out of digit 15 |
| cmp_eq | output | 1 | Compare: A equals B |
| cmp_lt | output | 1 | Compare: A less than B |
| cmp_gt | output | 1 | Compare: A greater than B |
| bad_digit | output | 1 | An operand nibble exceeded 9 |

## Verification
The hardest case to reach is a carry or borrow that must travel the whole sixteen-digit chain. Random digits almost never produce it, because every digit would have to propagate. The stimulus therefore includes directed operands for this case: all nines plus one, all nines plus all nines, and equal operands subtracted or compared. Equal operands make every digit propagate the injected carry. Nines near a single low-order zero stop the chain early, which checks that the carry stops where it should. Random valid operands and operands with a single bad nibble at a random position fill the remaining cycles.

// File: rtl/dec_addsub_pkg.sv
package dec_addsub_pkg;
   localparam int unsigned NIB_W = 4;
   localparam int unsigned OP_W  = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 2'd0,
      OP_SUB  = 2'd1,
      OP_CMP  = 2'd2,
      OP_CMP2 = 2'd3
   } dec_op_e;

   localparam int unsigned CARRY_RIPPLE = 0;
   localparam int unsigned CARRY_PREFIX = 1;
endpackage

// File: rtl/dec_digit_pre.sv
module dec_digit_pre
   import dec_addsub_pkg::*;
(
   input  logic [NIB_W-1:0] a_d,
   input  logic [NIB_W-1:0] b_d,
   input  logic             sub,
   output logic [NIB_W-1:0] s0,
   output logic [NIB_W-1:0] s1,
   output logic [NIB_W-1:0] s0_fix,
   output logic [NIB_W-1:0] s1_fix,
   output logic             gen,
   output logic             prop
);
   localparam logic [NIB_W-1:0] FIX_ADD = NIB_W'(6);
   localparam logic [NIB_W-1:0] FIX_SUB = NIB_W'(10);   // -6 modulo 16

   logic [NIB_W-1:0] bx;
   logic [NIB_W:0]   sum0;
   logic [NIB_W:0]   sum1;
   logic [NIB_W-1:0] fix;

   always_comb begin
      bx   = sub ? ~b_d : b_d;
      sum0 = {1'b0, a_d} + {1'b0, bx};
      sum1 = sum0 + (NIB_W+1)'(1);
      fix  = sub ? FIX_SUB : FIX_ADD;
      s0     = sum0[NIB_W-1:0];
      s1     = sum1[NIB_W-1:0];
      s0_fix = sum0[NIB_W-1:0] + fix;
      s1_fix = sum1[NIB_W-1:0] + fix;
      if (sub) begin
         gen  = sum0[NIB_W];
         prop = sum1[NIB_W];
      end else begin
         gen  = (sum0 > (NIB_W+1)'(9));
         prop = (sum1 > (NIB_W+1)'(9));
      end
   end
endmodule

// File: rtl/dec_carry_net.sv
module dec_carry_net
   import dec_addsub_pkg::*;
#(
   parameter int unsigned DIGITS = 16,
   parameter int unsigned STYLE  = CARRY_PREFIX
) (
   input  logic [DIGITS-1:0] gen,
   input  logic [DIGITS-1:0] prop,
   input  logic              cin,
   output logic [DIGITS:0]   carry
);
   localparam int unsigned LEVELS = (DIGITS > 1) ? $clog2(DIGITS) : 1;

   if (DIGITS < 1) begin : g_bad_digits
      $error("dec_carry_net: DIGITS must be at least 1");
   end
   if (STYLE > CARRY_PREFIX) begin : g_bad_style
      $error("dec_carry_net: unknown STYLE");
   end

   if (STYLE == CARRY_RIPPLE) begin : g_ripple
      always_comb begin
         carry[0] = cin;
         for (int i = 0; i < int'(DIGITS); i++) begin
            carry[i+1] = gen[i] | (prop[i] & carry[i]);
         end
      end
   end else begin : g_prefix
      always_comb begin
         logic [DIGITS-1:0] gv;
         logic [DIGITS-1:0] pv;
         logic [DIGITS-1:0] ng;
         logic [DIGITS-1:0] np;
         gv = gen;
         pv = prop;
         gv[0] = gen[0] | (prop[0] & cin);
         for (int lv = 0; lv < int'(LEVELS); lv++) begin
            ng = gv;
            np = pv;
            for (int i = 0; i < int'(DIGITS); i++) begin
               if (((i >> lv) & 1) == 1) begin
                  int j;
                  j = ((i >> lv) << lv) - 1;
                  ng[i] = gv[i] | (pv[i] & gv[j]);
                  np[i] = pv[i] & pv[j];
               end
            end
            gv = ng;
            pv = np;
         end
         carry = {gv, cin};
      end
   end
endmodule

// File: rtl/dec_digit_sel.sv
module dec_digit_sel
   import dec_addsub_pkg::*;
(
   input  logic [NIB_W-1:0] s0,
   input  logic [NIB_W-1:0] s1,
   input  logic [NIB_W-1:0] s0_fix,
   input  logic [NIB_W-1:0] s1_fix,
   input  logic             sub,
   input  logic             cin,
   input  logic             cout,
   output logic [NIB_W-1:0] digit
);
   logic use_fix;

   always_comb begin
      // add corrects when the digit carries, subtract when it does not
      use_fix = sub ? ~cout : cout;
      unique case ({cin, use_fix})
         2'b00:   digit = s0;
         2'b01:   digit = s0_fix;
         2'b10:   digit = s1;
         default: digit = s1_fix;
      endcase
   end
endmodule

// File: rtl/dec_addsub.sv
module dec_addsub
   import dec_addsub_pkg::*;
#(
   parameter int unsigned DIGITS      = 16,
   parameter int unsigned CARRY_STYLE = CARRY_PREFIX,
   localparam int unsigned W          = DIGITS * NIB_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   output logic            out_valid,
   output logic [W-1:0]    res_q,
   output logic            carry_q,
   output logic            cmp_eq,
   output logic            cmp_lt,
   output logic            cmp_gt,
   output logic            bad_digit
);
   if (DIGITS < 1) begin : g_bad_digits
      $error("dec_addsub: DIGITS must be at least 1");
   end

   logic              sub_mode;
   logic              cmp_mode;
   logic [DIGITS-1:0] gen;
   logic [DIGITS-1:0] prop;
   logic [DIGITS:0]   carry;
   logic [W-1:0]      sum_w;
   logic              any_bad;
   logic              is_zero;

   assign cmp_mode = op_i[1];
   assign sub_mode = op_i[0] | op_i[1];

   for (genvar d = 0; d < int'(DIGITS); d++) begin : g_digit
      logic [NIB_W-1:0] s0, s1, s0f, s1f;

      dec_digit_pre u_pre (
         .a_d    (a_i[d*NIB_W +: NIB_W]),
         .b_d    (b_i[d*NIB_W +: NIB_W]),
         .sub    (sub_mode),
         .s0     (s0),
         .s1     (s1),
         .s0_fix (s0f),
         .s1_fix (s1f),
         .gen    (gen[d]),
         .prop   (prop[d])
      );

      dec_digit_sel u_sel (
         .s0     (s0),
         .s1     (s1),
         .s0_fix (s0f),
         .s1_fix (s1f),
         .sub    (sub_mode),
         .cin    (carry[d]),
         .cout   (carry[d+1]),
         .digit  (sum_w[d*NIB_W +: NIB_W])
      );
   end

   dec_carry_net #(
      .DIGITS (DIGITS),
      .STYLE  (CARRY_STYLE)
   ) u_net (
      .gen   (gen),
      .prop  (prop),
      .cin   (sub_mode),
      .carry (carry)
   );

   always_comb begin
      any_bad = 1'b0;
      for (int d = 0; d < int'(DIGITS); d++) begin
         if (a_i[d*NIB_W +: NIB_W] > NIB_W'(9)) any_bad = 1'b1;
         if (b_i[d*NIB_W +: NIB_W] > NIB_W'(9)) any_bad = 1'b1;
      end
      is_zero = (sum_w == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_q     <= '0;
         carry_q   <= 1'b0;
         cmp_eq    <= 1'b0;
         cmp_lt    <= 1'b0;
         cmp_gt    <= 1'b0;
         bad_digit <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            bad_digit <= any_bad;
            if (cmp_mode) begin
               cmp_eq <= is_zero;
               cmp_lt <= ~carry[DIGITS];
               cmp_gt <= carry[DIGITS] & ~is_zero;
            end else begin
               res_q   <= sum_w;
               carry_q <= carry[DIGITS];
            end
         end
      end
   end

   // Assertions

   always_comb begin
      if (rst_n && in_valid && !any_bad) begin
         for (int d = 0; d < int'(DIGITS); d++) begin
            p_digit_range_r9: assert (sum_w[d*NIB_W +: NIB_W] <= NIB_W'(9))
               else $error("result nibble %0d out of range", d);
         end
      end
   end

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_cmp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmp_eq, cmp_lt, cmp_gt}));

   p_cmp_keeps_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_i[1]) |=> ($stable(res_q) && $stable(carry_q)));

   p_arith_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_i[1]) |=> $stable({cmp_eq, cmp_lt, cmp_gt}));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_q) && $stable(carry_q) && $stable(bad_digit)
                     && $stable({cmp_eq, cmp_lt, cmp_gt})));
endmodule

// File: tb/dec_addsub_tb_top.sv
module dec_addsub_tb_top;
   localparam int DIG = 16;
   localparam longint unsigned MODV = 64'd10000000000000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [63:0] a_i = '0;
   logic [63:0] b_i = '0;
   logic        out_valid, carry_q, cmp_eq, cmp_lt, cmp_gt, bad_digit;
   logic [63:0] res_q;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [63:0] e_res;
   logic        e_carry, e_eq, e_lt, e_gt, e_bad, e_valid;
   bit          res_known, cmp_known;
   string       tag_res, tag_cmp, tag_bad;

   always #2 clk = ~clk;   // 250 MHz

   dec_addsub dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .out_valid(out_valid), .res_q(res_q),
      .carry_q(carry_q), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .cmp_gt(cmp_gt),
      .bad_digit(bad_digit)
   );

   function automatic longint unsigned to_int(logic [63:0] v);
      longint unsigned r = 0;
      for (int d = DIG-1; d >= 0; d--) r = r*10 + longint'(v[d*4 +: 4]);
      return r;
   endfunction

   function automatic logic [63:0] to_bcd(longint unsigned x);
      logic [63:0] r = '0;
      for (int d = 0; d < DIG; d++) begin
         r[d*4 +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   function automatic logic [63:0] rnd_bcd();
      logic [63:0] r;
      for (int d = 0; d < DIG; d++) r[d*4 +: 4] = 4'($urandom_range(0, 9));
      return r;
   endfunction

   function automatic bit digits_ok(logic [63:0] v);
      for (int d = 0; d < DIG; d++) if (v[d*4 +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R1", "out_valid", 64'(out_valid), 64'(e_valid));
      chk(tag_bad, "bad_digit", 64'(bad_digit), 64'(e_bad));
      if (res_known) begin
         chk(tag_res, "res_q", res_q, e_res);
         chk(tag_res, "carry_q", 64'(carry_q), 64'(e_carry));
         chk("R9", "res_q digits", 64'(digits_ok(res_q)), 64'd1);
      end
      if (cmp_known)
         chk(tag_cmp, "cmp flags", 64'({cmp_eq, cmp_lt, cmp_gt}), 64'({e_eq, e_lt, e_gt}));
   endtask

   // apply one request (or idle), update the reference, check after the edge
   task automatic step(bit v, logic [1:0] op, logic [63:0] a, logic [63:0] b);
      longint unsigned ai, bi, s;
      bit bad;
      in_valid = v; op_i = op; a_i = a; b_i = b;
      bad = !digits_ok(a) || !digits_ok(b);
      e_valid = v;
      if (!v) begin
         tag_res = "R8"; tag_cmp = "R8"; tag_bad = "R8";
      end else begin
         e_bad = bad;
         tag_bad = "R5";
         ai = to_int(a); bi = to_int(b);
         if (op[1]) begin
            tag_res = "R4"; tag_cmp = "R4";
            if (bad) cmp_known = 0;
            else begin
               cmp_known = 1;
               e_eq = (ai == bi); e_lt = (ai < bi); e_gt = (ai > bi);
            end
         end else begin
            tag_res = op[0] ? "R3" : "R2"; tag_cmp = "R6";
            if (bad) res_known = 0;
            else begin
               res_known = 1;
               if (!op[0]) begin
                  s = ai + bi;
                  e_carry = (s >= MODV);
                  e_res = to_bcd(s % MODV);
               end else begin
                  e_carry = (ai >= bi);
                  e_res = (ai >= bi) ? to_bcd(ai - bi) : to_bcd(MODV - (bi - ai));
               end
            end
         end
      end
      @(posedge clk); #1;
      check_all();
   endtask

   localparam logic [63:0] NINES = 64'h9999_9999_9999_9999;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R7: reset state
      chk("R7", "reset res_q", res_q, '0);
      chk("R7", "reset flags", 64'({out_valid, carry_q, cmp_eq, cmp_lt, cmp_gt, bad_digit}), '0);
      rst_n = 1'b1;
      e_res = '0; e_carry = 0; e_eq = 0; e_lt = 0; e_gt = 0; e_bad = 0; e_valid = 0;
      res_known = 1; cmp_known = 1;
      tag_res = "R7"; tag_cmp = "R7"; tag_bad = "R7";
      step(0, 2'd0, '0, '0);
      // R2 long carry chains
      step(1, 2'd0, NINES, 64'h1);
      step(1, 2'd0, NINES, NINES);
      step(1, 2'd0, 64'h0999_9999_9999_9999, 64'h1);
      step(1, 2'd0, 64'h9999_9999_9999_9909, 64'h1);
      step(1, 2'd0, 64'h0, 64'h0);
      // R3 subtraction, negative, equal, borrow across all digits
      step(1, 2'd1, 64'h1000_0000_0000_0000, 64'h1);
      step(1, 2'd1, 64'h1, 64'h2);
      step(1, 2'd1, 64'h0, NINES);
      step(1, 2'd1, 64'h1234_5678_9012_3456, 64'h1234_5678_9012_3456);
      // R4 compare, and R6 flags kept through arithmetic
      step(1, 2'd2, 64'h5, 64'h5);
      step(1, 2'd0, 64'h7, 64'h8);
      step(1, 2'd3, 64'h4, 64'h5);
      step(1, 2'd2, NINES, 64'h0);
      step(1, 2'd1, 64'h3, 64'h9);
      // R8 idle
      step(0, 2'd0, NINES, NINES);
      step(0, 2'd2, 64'h1, 64'h2);
      // R5 bad digits
      step(1, 2'd0, 64'h0000_0000_0000_000A, 64'h1);
      step(1, 2'd0, 64'h1, 64'h2);
      step(1, 2'd2, 64'h1, 64'hF000_0000_0000_0000);
      step(1, 2'd2, 64'h3, 64'h3);
      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [63:0] ra, rb;
         int sel;
         ra = rnd_bcd(); rb = rnd_bcd();
         sel = $urandom_range(0, 15);
         if (sel == 0) ra[$urandom_range(0, 15)*4 +: 4] = 4'($urandom_range(10, 15));
         if (sel == 1) rb = ra;
         step(sel != 2, 2'($urandom_range(0, 3)), ra, rb);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule